// File: doc/BRIEF.md
# Start-Triggered Count-and-Flag Sequencer

This block pairs a three-state controller with a small datapath: a 4-bit counter and two single-bit flags, E and F. It waits in an idle state until a start request arrives. It then clears the counter and flag F, and counts once per clock. While counting, flag E copies one counter bit as it stood before that cycle's increment.

Counting stops when both upper counter bits are high. The controller then spends exactly one cycle in a finishing state, where F is set, and drops back to idle on the next clock. The counter value, both flags, the encoded state and a done strobe are visible at the ports.

Control decisions come from a two-bit state register, with status bits fed back from the counter. All register transfers for a state happen on the same clock edge that leaves that state.

Top module: `cnt_ctrl_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the state in idle and clears the counter, E and F. Reset takes priority over `start`.
- R2: In idle with `start` low, the state stays idle and the counter, E and F keep their values.
- R3: In idle with `start` high, the next edge moves the state to counting, clears the counter and F, and leaves E unchanged.
- R4: In every counting cycle the counter increments by one, modulo 16. `start` has no effect while counting.
- R5: In every counting cycle, E takes the value that counter bit 2 held before that cycle's increment.
- R6: A counting cycle whose pre-increment counter has bits 3 and 2 both at 1 moves the state to finishing. Any other counting cycle stays in counting. From a cleared counter this gives 13 counting cycles, ending with the counter at 13.
- R7: In the finishing state the next edge sets F and returns to idle. The counter and E hold, and `start` is ignored there.
- R8: `state_o` encodes idle as 2'b00, counting as 2'b01 and finishing as 2'b11. The code 2'b10 never appears after reset, and `done_o` is high exactly while `state_o` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, sampled only in idle |
| cnt_o | output | 4 | Counter register value |
| flag_e_o | output | 1 | Flag E |
| flag_f_o | output | 1 | Flag F |
| state_o | output | 2 | Encoded controller state |
| done_o | output | 1 | High while in the finishing state |

## Verification
The assertions assume that `rst` is held high for at least one edge before any other activity. They also assume `start` is a synchronous level, stable around each rising edge. Several properties compare against `$past`, so they treat only cycles after reset is released as meaningful.

The bench respects both assumptions by driving `start` and `rst` on falling edges only. It also asserts reset before the first released cycle. Within those rules, `start` is deliberately held high during counting and finishing, so the properties that claim it is ignored get exercised.

// File: rtl/cnt_ctrl_pkg.sv
package cnt_ctrl_pkg;

    // State codes; bit 0 and bit 1 follow the two next-state equations
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_COUNT  = 2'b01,
        ST_SPARE  = 2'b10,
        ST_FINISH = 2'b11
    } state_e;

    // Control word from the controller to the datapath
    typedef struct packed {
        logic clr_cnt_f;   // clear counter and flag F
        logic inc_cnt;     // increment counter
        logic upd_e;       // load E from the tracked counter bit
        logic set_f;       // set flag F
    } ctrl_t;

endpackage

// File: rtl/cnt_ctrl_fsm.sv
module cnt_ctrl_fsm
    import cnt_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   exit_hit,
    output state_e state_q,
    output ctrl_t  ctrl
);

    typedef struct packed {
        state_e st;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        ctrl = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctrl.clr_cnt_f = 1'b1;
                    r_d.st         = ST_COUNT;
                end
            end
            ST_COUNT: begin
                ctrl.inc_cnt = 1'b1;
                ctrl.upd_e   = 1'b1;
                if (exit_hit) begin
                    r_d.st = ST_FINISH;
                end
            end
            ST_FINISH: begin
                ctrl.set_f = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: begin
                // spare code: recover without touching the datapath
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q = r_q.st;

endmodule

// File: rtl/cnt_ctrl_dp.sv
module cnt_ctrl_dp
    import cnt_ctrl_pkg::*;
#(
    parameter int              CNT_W     = 4,
    parameter int              E_BIT     = 2,
    parameter logic [CNT_W-1:0] EXIT_MASK = 4'b1100
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    output logic [CNT_W-1:0] cnt_q,
    output logic             e_q,
    output logic             f_q,
    output logic             exit_hit
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             e;
        logic             f;
    } dp_t;

    dp_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctrl.clr_cnt_f) begin
            r_d.cnt = '0;
            r_d.f   = 1'b0;
        end
        if (ctrl.inc_cnt) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        if (ctrl.upd_e) begin
            r_d.e = r_q.cnt[E_BIT];
        end
        if (ctrl.set_f) begin
            r_d.f = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Loop exit: every bit selected by the mask must be high
    logic [CNT_W-1:0] hit_bits;
    for (genvar i = 0; i < CNT_W; i++) begin : g_hit
        if (EXIT_MASK[i]) begin : g_sel
            assign hit_bits[i] = r_q.cnt[i];
        end else begin : g_free
            assign hit_bits[i] = 1'b1;
        end
    end
    assign exit_hit = &hit_bits;

    assign cnt_q = r_q.cnt;
    assign e_q   = r_q.e;
    assign f_q   = r_q.f;

endmodule

// File: rtl/cnt_ctrl_top.sv
module cnt_ctrl_top
    import cnt_ctrl_pkg::*;
#(
    parameter int               CNT_W     = 4,
    parameter int               E_BIT     = 2,
    parameter logic [CNT_W-1:0] EXIT_MASK = 4'b1100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_e_o,
    output logic             flag_f_o,
    output logic [1:0]       state_o,
    output logic             done_o
);

    state_e st;
    ctrl_t  ctrl;
    logic   exit_hit;

    cnt_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .exit_hit (exit_hit),
        .state_q  (st),
        .ctrl     (ctrl)
    );

    cnt_ctrl_dp #(
        .CNT_W     (CNT_W),
        .E_BIT     (E_BIT),
        .EXIT_MASK (EXIT_MASK)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .cnt_q    (cnt_o),
        .e_q      (flag_e_o),
        .f_q      (flag_f_o),
        .exit_hit (exit_hit)
    );

    assign state_o = st;
    assign done_o  = (st == ST_FINISH);

endmodule

// File: rtl/cnt_ctrl_chk.sv
module cnt_ctrl_chk #(
    parameter int               CNT_W     = 4,
    parameter int               E_BIT     = 2,
    parameter logic [CNT_W-1:0] EXIT_MASK = 4'b1100
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] cnt_o,
    input logic             flag_e_o,
    input logic             flag_f_o,
    input logic [1:0]       state_o,
    input logic             done_o
);

    logic at_exit;
    assign at_exit = ((cnt_o & EXIT_MASK) == EXIT_MASK);

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_o == 2'b00 && cnt_o == '0 && !flag_e_o && !flag_f_o)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && !start) |=>
            (state_o == 2'b00 && $stable(cnt_o) && $stable(flag_e_o) && $stable(flag_f_o))); // R2

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && start) |=>
            (state_o == 2'b01 && cnt_o == '0 && !flag_f_o && $stable(flag_e_o))); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R4

    AST_E_TRACK: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01) |=> (flag_e_o == $past(cnt_o[E_BIT]))); // R5

    AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && at_exit) |=> (state_o == 2'b11)); // R6

    AST_LOOP_STAY: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && !at_exit) |=> (state_o == 2'b01)); // R6

    AST_FINISH_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b11) |=>
            (state_o == 2'b00 && flag_f_o && $stable(cnt_o) && $stable(flag_e_o))); // R7

    AST_NO_SPARE: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'b10)); // R8

    AST_DONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (done_o == (state_o == 2'b11))); // R8

endmodule

bind cnt_ctrl_top cnt_ctrl_chk #(
    .CNT_W     (CNT_W),
    .E_BIT     (E_BIT),
    .EXIT_MASK (EXIT_MASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cnt_o    (cnt_o),
    .flag_e_o (flag_e_o),
    .flag_f_o (flag_f_o),
    .state_o  (state_o),
    .done_o   (done_o)
);

// File: tb/test_cnt_ctrl_top.sv
module test_cnt_ctrl_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] cnt_o;
    logic       flag_e_o, flag_f_o, done_o;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit ended  = 1'b0;

    // Reference model state, built from the requirements
    logic [1:0] m_st;
    logic [3:0] m_a;
    logic       m_e, m_f;
    string      m_tag;

    always #10 clk = ~clk;   // 50 MHz

    cnt_ctrl_top i_cnt_ctrl_top (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cnt_o    (cnt_o),
        .flag_e_o (flag_e_o),
        .flag_f_o (flag_f_o),
        .state_o  (state_o),
        .done_o   (done_o)
    );

    // Segment table: {start, cycles[7:0], state[1:0], cnt[3:0], e, f}
    localparam int NSEG = 10;
    localparam logic [16:0] SEG [NSEG] = '{
        {1'b0, 8'd3,  2'b00, 4'd0,  1'b0, 1'b0},  // R2 idle hold
        {1'b1, 8'd1,  2'b01, 4'd0,  1'b0, 1'b0},  // R3 start
        {1'b0, 8'd5,  2'b01, 4'd5,  1'b1, 1'b0},  // R4 R5 count, E from pre-value 4
        {1'b0, 8'd7,  2'b01, 4'd12, 1'b0, 1'b0},  // R6 no exit at 11, E from 11
        {1'b0, 8'd1,  2'b11, 4'd13, 1'b1, 1'b0},  // R6 exit on 12
        {1'b1, 8'd1,  2'b00, 4'd13, 1'b1, 1'b1},  // R7 finish, start ignored
        {1'b1, 8'd1,  2'b01, 4'd0,  1'b1, 1'b0},  // R3 restart at once, E kept
        {1'b1, 8'd13, 2'b11, 4'd13, 1'b1, 1'b0},  // R4 R6 start ignored while counting
        {1'b0, 8'd1,  2'b00, 4'd13, 1'b1, 1'b1},  // R7
        {1'b0, 8'd2,  2'b00, 4'd13, 1'b1, 1'b1}   // R2
    };

    task automatic model_reset();
        m_st = 2'b00; m_a = 4'd0; m_e = 1'b0; m_f = 1'b0;
    endtask

    task automatic model_step(input logic s);
        case (m_st)
            2'b00: begin
                if (s) begin
                    m_a = 4'd0; m_f = 1'b0; m_st = 2'b01; m_tag = "R3";
                end else begin
                    m_tag = "R2";
                end
            end
            2'b01: begin
                m_e = m_a[2];
                m_tag = (m_a[3] && m_a[2]) ? "R6" : "R4/R5";
                if (m_a[3] && m_a[2]) m_st = 2'b11;
                m_a = m_a + 4'd1;
            end
            default: begin
                m_f = 1'b1; m_st = 2'b00; m_tag = "R7";
            end
        endcase
    endtask

    task automatic compare(input string tag, input logic [1:0] st, input logic [3:0] a,
                           input logic e, input logic f);
        checks++;
        if (state_o !== st || cnt_o !== a || flag_e_o !== e || flag_f_o !== f
            || done_o !== (st == 2'b11)) begin
            errors++;
            $display("FAIL %s: got st=%b cnt=%0d e=%b f=%b done=%b, expected st=%b cnt=%0d e=%b f=%b done=%b (R8 done)",
                     tag, state_o, cnt_o, flag_e_o, flag_f_o, done_o,
                     st, a, e, f, (st == 2'b11));
        end
    endtask

    // One clock: drive at falling edge, sample at the next falling edge
    task automatic cycle(input logic s);
        start = s;
        model_step(s);
        @(posedge clk);
        @(negedge clk);
        compare(m_tag, m_st, m_a, m_e, m_f);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        model_reset();
        m_tag = "R1";
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare("R1 reset", 2'b00, 4'd0, 1'b0, 1'b0);
        rst = 1'b0;

        // Table walk: every cycle against the model, segment ends against the table
        for (int k = 0; k < NSEG; k++) begin
            for (int c = 0; c < int'(SEG[k][15:8]); c++) begin
                cycle(SEG[k][16]);
            end
            compare($sformatf("R8 segment %0d", k), SEG[k][7:6], SEG[k][5:2],
                    SEG[k][1], SEG[k][0]);
        end

        // R1: reset in the middle of counting, with start held high
        cycle(1'b1);
        for (int c = 0; c < 6; c++) cycle(1'b0);
        rst = 1'b1;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        model_reset();
        compare("R1 mid-count reset", 2'b00, 4'd0, 1'b0, 1'b0);
        rst = 1'b0;
        start = 1'b0;

        // R2: idle with start low after reset keeps everything
        for (int c = 0; c < 2; c++) cycle(1'b0);
        compare("R2 idle after reset", 2'b00, 4'd0, 1'b0, 1'b0);

        // R6: full loop once more from reset, 13 counting cycles then finish
        cycle(1'b1);
        for (int c = 0; c < 13; c++) cycle(1'b0);
        compare("R6 exit count", 2'b11, 4'd13, 1'b1, 1'b0);
        cycle(1'b0);
        compare("R7 back to idle", 2'b00, 4'd13, 1'b1, 1'b1);

        finish_run();
    end

endmodule